// File: doc/BRIEF.md
# Management Interface Frame Master

This block runs single register transactions on a two-wire PHY management bus. A host raises a one-cycle request that carries a PHY address, a register number, a read/write flag and, for writes, a 16-bit data word. The engine then produces the management clock and shifts out a complete frame on the serial data line. The data line is bidirectional, so it is modelled as three signals: an output value, an output enable and an input value.

The management clock comes from the system clock. A parameter sets how many system cycles each clock phase lasts. The output value and enable change only while the management clock is low. Input bits are taken at the end of the high phase. While a frame is running, `busy` is high. When the frame ends, a one-cycle `done` pulse appears. For a read, the word collected from the PHY appears on `rdData` in that same cycle and stays there until another read completes.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, busy, done, mdc, mdo and mdoe are all low and rdData is zero.
- R2: A request is taken only in a cycle where busy is low. A request raised while busy is high does not change the running frame and does not start another frame afterwards.
- R3: Each low phase and each high phase of mdc lasts exactly HALF_CYC system cycles. A frame of N bits keeps busy high for N*2*HALF_CYC cycles.
- R4: Every frame opens with 32 bit times in which mdoe=1 and mdo=1.
- R5: After the opening run come these bits, all driven: the start pair 0,1; then the operation pair (1,0 for a read, 0,1 for a write); then the 5-bit PHY address; then the 5-bit register number. Address and register number go out most significant bit first.
- R6: A write frame continues with two released bits (mdoe=0), then the 16 data bits driven most significant bit first, then one released bit. The frame totals 65 mdc rising edges.
- R7: A read frame continues with one released bit, then 16 released bits sampled from mdi, then one more released bit. The frame totals 64 mdc rising edges. The first sampled bit becomes rdData bit 15.
- R8: mdo and mdoe hold their values while mdc is high. mdi is taken on the system edge that ends the high phase. mdo is low whenever mdoe is low.
- R9: At the end of a frame, mdc, mdo and mdoe are low and busy falls. done is high for exactly that one cycle.
- R10: rdData changes only in the done cycle of a read frame. A write frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle transaction request |
| reqWrite | input | 1 | 1 = write frame, 0 = read frame |
| reqPhyAddr | input | ADDR_W | Target PHY address |
| reqRegAddr | input | ADDR_W | Target register number |
| reqWrData | input | DATA_W | Data for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdData | output | DATA_W | Word captured by the last read |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data output value |
| mdoe | output | 1 | Serial data output enable |
| mdi | input | 1 | Serial data input |

## Verification
If the bit index is wrong, the effect shows at the next mdc rising edge. The header comes out shifted, or a released bit is driven, or the frame ends one edge early or late. Each of these is seen as a changed mdc edge count, or as a busy window whose length is not a multiple of 2*HALF_CYC. If the phase counter is wrong, the first half-period of mdc is already the wrong length. If the capture path is wrong, rdData holds a wrong value in the done cycle of the first read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Strobes from the sequencer to the datapath, valid for one system cycle.
  typedef struct packed {
    logic load;      // take a new request into the shift registers
    logic shiftOut;  // one driven bit has gone out
    logic capture;   // take one input bit
    logic latchRd;   // copy the captured word to the read data output
  } mdioStrobe_t;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int PRE_LEN  = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdoe,
  output mdioStrobe_t strobe
);

  localparam int HDR_BITS = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int RD_BITS  = HDR_BITS + DATA_W + 2;
  localparam int WR_BITS  = HDR_BITS + DATA_W + 3;
  localparam int IDX_W    = $clog2(WR_BITS + 1);
  localparam int PH_W     = $clog2(HALF_CYC + 1);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t        state;
  logic             isWrite;
  logic [IDX_W-1:0] bitIdx;
  logic [PH_W-1:0]  phaseCnt;
  logic             mdcQ;
  logic             mdoeQ;
  logic             doneQ;

  logic accept;
  logic phaseEnd;
  logic bitEnd;
  logic lastBit;
  logic inCapture;

  // Tells whether bit position idx is driven by this engine.
  function automatic logic driveAt(input logic [IDX_W-1:0] idx, input logic wr);
    int i;
    i = int'(idx);
    return (i < HDR_BITS) ||
           (wr && (i >= HDR_BITS + 2) && (i < HDR_BITS + 2 + DATA_W));
  endfunction

  always_comb begin
    accept    = (state == ST_IDLE) && reqValid;
    phaseEnd  = (phaseCnt == PH_W'(HALF_CYC - 1));
    bitEnd    = (state == ST_RUN) && mdcQ && phaseEnd;
    lastBit   = isWrite ? (bitIdx == IDX_W'(WR_BITS - 1))
                        : (bitIdx == IDX_W'(RD_BITS - 1));
    inCapture = !isWrite && (int'(bitIdx) >= HDR_BITS + 1) &&
                (int'(bitIdx) <= HDR_BITS + DATA_W);
    strobe.load     = accept;
    strobe.shiftOut = bitEnd && mdoeQ;
    strobe.capture  = bitEnd && inCapture;
    strobe.latchRd  = bitEnd && lastBit && !isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isWrite  <= 1'b0;
      bitIdx   <= '0;
      phaseCnt <= '0;
      mdcQ     <= 1'b0;
      mdoeQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        state    <= ST_RUN;
        isWrite  <= reqWrite;
        bitIdx   <= '0;
        phaseCnt <= '0;
        mdcQ     <= 1'b0;
        mdoeQ    <= 1'b1;
      end else if (state == ST_RUN) begin
        if (!phaseEnd) begin
          phaseCnt <= phaseCnt + PH_W'(1);
        end else begin
          phaseCnt <= '0;
          if (!mdcQ) begin
            mdcQ <= 1'b1;
          end else begin
            mdcQ <= 1'b0;
            if (lastBit) begin
              state <= ST_IDLE;
              mdoeQ <= 1'b0;
              doneQ <= 1'b1;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
              mdoeQ  <= driveAt(bitIdx + IDX_W'(1), isWrite);
            end
          end
        end
      end
    end
  end

  assign busy = (state == ST_RUN);
  assign done = doneQ;
  assign mdc  = mdcQ;
  assign mdoe = mdoeQ;

endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqPhyAddr,
  input  logic [ADDR_W-1:0] reqRegAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              mdi,
  input  logic              mdoe,
  output logic              mdo,
  output logic [DATA_W-1:0] rdData
);

  localparam int SH_W = PRE_LEN + 4 + 2 * ADDR_W + DATA_W;

  logic [SH_W-1:0]   outShift;
  logic [DATA_W-1:0] inShift;
  logic [DATA_W-1:0] rdQ;
  logic [SH_W-1:0]   frameImage;

  // Every driven bit of the frame in send order. Released bits are not in it.
  always_comb begin
    frameImage = {{PRE_LEN{1'b1}}, START_PAT,
                  (reqWrite ? OP_WRITE : OP_READ),
                  reqPhyAddr, reqRegAddr,
                  (reqWrite ? reqWrData : {DATA_W{1'b0}})};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      inShift  <= '0;
      rdQ      <= '0;
    end else begin
      if (strobe.load) begin
        outShift <= frameImage;
        inShift  <= '0;
      end else begin
        if (strobe.shiftOut) outShift <= {outShift[SH_W-2:0], 1'b0};
        if (strobe.capture)  inShift  <= {inShift[DATA_W-2:0], mdi};
      end
      if (strobe.latchRd) rdQ <= inShift;
    end
  end

  assign mdo    = mdoe & outShift[SH_W-1];
  assign rdData = rdQ;

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int PRE_LEN  = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqPhyAddr,
  input  logic [ADDR_W-1:0] reqRegAddr,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              mdc,
  output logic              mdo,
  output logic              mdoe,
  input  logic              mdi
);

  mdioStrobe_t strobe;
  logic        mdoeInt;

  mdio_ctrl #(
    .HALF_CYC(HALF_CYC), .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .busy(busy), .done(done), .mdc(mdc), .mdoe(mdoeInt), .strobe(strobe)
  );

  mdio_dpath #(
    .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqPhyAddr(reqPhyAddr), .reqRegAddr(reqRegAddr), .reqWrData(reqWrData),
    .mdi(mdi), .mdoe(mdoeInt), .mdo(mdo), .rdData(rdData)
  );

  assign mdoe = mdoeInt;

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int HALF_CYC = 4,
  parameter int PRE_LEN  = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              busy,
  input logic              done,
  input logic              mdc,
  input logic              mdo,
  input logic              mdoe,
  input logic [DATA_W-1:0] rdData
);

  localparam int HDR_BITS = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int RD_EDGES = HDR_BITS + DATA_W + 2;
  localparam int WR_EDGES = HDR_BITS + DATA_W + 3;
  localparam int RL_W     = $clog2(HALF_CYC + 1);

  logic [RL_W-1:0] runLen;
  logic [7:0]      riseCnt;
  logic            prevMdc;
  logic            wrSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen  <= '0;
      riseCnt <= '0;
      prevMdc <= 1'b0;
      wrSeen  <= 1'b0;
    end else begin
      prevMdc <= mdc;
      if (!busy || runLen == RL_W'(HALF_CYC - 1)) runLen <= '0;
      else runLen <= runLen + RL_W'(1);
      if (reqValid && !busy) begin
        riseCnt <= '0;
        wrSeen  <= reqWrite;
      end else if (mdc && !prevMdc) begin
        riseCnt <= riseCnt + 8'd1;
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdoe && !mdo)); // R9
  AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !mdoe |-> !mdo); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rdData)); // R10
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runLen != RL_W'(HALF_CYC - 1)) |=> $stable(mdc)); // R3
  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runLen == RL_W'(HALF_CYC - 1)) |=> (mdc != $past(mdc))); // R3
  AST_WR_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (done && wrSeen) |-> (riseCnt == 8'(WR_EDGES))); // R6
  AST_RD_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (done && !wrSeen) |-> (riseCnt == 8'(RD_EDGES))); // R7

endmodule

bind mdio_frame_master mdio_frame_master_chk #(
  .HALF_CYC(HALF_CYC), .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .busy(busy), .done(done), .mdc(mdc), .mdo(mdo), .mdoe(mdoe), .rdData(rdData)
);

// File: tb/mdio_frame_master_tb.sv
`timescale 1ns/1ps
module mdio_frame_master_tb;

  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [4:0]  reqPhyAddr = '0;
  logic [4:0]  reqRegAddr = '0;
  logic [15:0] reqWrData = '0;
  logic        busy, done, mdc, mdo, mdoe, mdi;
  logic [15:0] rdData;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // bench-side PHY model state
  logic [15:0] phyVal = 16'h0;
  int   riseCnt = 0;
  int   fallCnt = 0;
  int   glitch = 0;
  logic prevMdc = 1'b0;
  logic pO = 1'b0, pOe = 1'b0;
  logic seenOe [0:79];
  logic seenO  [0:79];

  always #2.5 clk = ~clk;

  mdio_frame_master #(.HALF_CYC(H)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhyAddr(reqPhyAddr), .reqRegAddr(reqRegAddr), .reqWrData(reqWrData),
    .busy(busy), .done(done), .rdData(rdData), .mdc(mdc), .mdo(mdo),
    .mdoe(mdoe), .mdi(mdi)
  );

  // PHY answer: bit time k holds phyVal[62-k] for k in 47..62
  assign mdi = (fallCnt >= 47 && fallCnt <= 62) ? phyVal[62 - fallCnt] : 1'b1;

  always @(negedge clk) begin
    if (mdc && !prevMdc) begin
      if (riseCnt < 80) begin
        seenOe[riseCnt] = mdoe;
        seenO[riseCnt]  = mdo;
      end
      riseCnt = riseCnt + 1;
    end
    if (!mdc && prevMdc) fallCnt = fallCnt + 1;
    if (mdc && prevMdc && (mdo != pO || mdoe != pOe)) glitch = glitch + 1;
    prevMdc = mdc;
    pO = mdo;
    pOe = mdoe;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected {oe, o} at bit time k
  function automatic logic [1:0] expBit(int k, bit wr, logic [4:0] pa, logic [4:0] ra,
                                        logic [15:0] wd);
    if (k < 32) return 2'b11;
    if (k == 32) return 2'b10;
    if (k == 33) return 2'b11;
    if (k == 34) return wr ? 2'b10 : 2'b11;
    if (k == 35) return wr ? 2'b11 : 2'b10;
    if (k <= 40) return {1'b1, pa[40 - k]};
    if (k <= 45) return {1'b1, ra[45 - k]};
    if (wr && k >= 48 && k <= 63) return {1'b1, wd[63 - k]};
    return 2'b00;
  endfunction

  task automatic runFrame(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] pv, input bit inject);
    int nExp, busyCyc, badPre, badHdr, badTail;
    string tailTag;
    logic [1:0] e;
    nExp = wr ? 65 : 64;
    tailTag = wr ? "R6" : "R7";
    phyVal = pv;
    riseCnt = 0;
    fallCnt = 0;
    glitch = 0;
    @(negedge clk);
    check(!busy, "R2 idle before request", busy, 0);
    reqValid = 1'b1; reqWrite = wr; reqPhyAddr = pa; reqRegAddr = ra; reqWrData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    busyCyc = 0;
    while (busy && busyCyc < 2000) begin
      busyCyc = busyCyc + 1;
      if (inject && busyCyc == 10) begin
        reqValid = 1'b1; reqWrite = ~wr; reqPhyAddr = ~pa; reqRegAddr = ~ra; reqWrData = ~wd;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(busyCyc == nExp * 2 * H, "R3 busy length", busyCyc, nExp * 2 * H);
    check(riseCnt == nExp, {tailTag, " edge count"}, riseCnt, nExp);
    badPre = 0; badHdr = 0; badTail = 0;
    for (int k = 0; k < nExp && k < riseCnt; k++) begin
      e = expBit(k, wr, pa, ra, wd);
      if ({seenOe[k], seenO[k]} != e) begin
        if (k < 32) badPre++;
        else if (k < 46) badHdr++;
        else badTail++;
      end
    end
    check(badPre == 0, "R4 opening run", badPre, 0);
    check(badHdr == 0, "R5 start/op/addr/reg", badHdr, 0);
    check(badTail == 0, {tailTag, " turnaround/data/release"}, badTail, 0);
    check(glitch == 0, "R8 stable while mdc high", glitch, 0);
    check(done && !mdc && !mdo && !mdoe, "R9 end state and done",
          {done, mdc, mdo, mdoe}, 4'b1000);
    if (!wr) check(rdData == pv, "R7 read data", rdData, pv);
    @(negedge clk);
    check(!done && !busy, inject ? "R2 no extra frame" : "R9 done one cycle",
          {done, busy}, 0);
  endtask

  initial begin
    logic [15:0] held;
    #12;
    @(negedge clk);
    check(!busy && !done && !mdc && !mdo && !mdoe && rdData == 0, "R1 reset state",
          {busy, done, mdc, mdo, mdoe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mdc && !mdoe && rdData == 0, "R1 after release",
          {busy, done, mdc, mdoe}, 0);
    // write sweep over every PHY address
    for (int a = 0; a < 32; a++)
      runFrame(1'b1, 5'(a), 5'(31 - a), 16'(a * 16'h0811 ^ 16'h5A3C), 16'h0, 1'b0);
    // read sweep with varied answers, corner words included
    for (int a = 0; a < 8; a++) begin
      logic [15:0] v;
      v = (a == 0) ? 16'h0000 : (a == 1) ? 16'hFFFF : 16'(a * 16'h1357 + 16'h8001);
      runFrame(1'b0, 5'(a * 4 + 1), 5'(a * 3), 16'h0, v, 1'b0);
    end
    // requests while busy, both frame kinds (R2)
    runFrame(1'b1, 5'h15, 5'h0A, 16'hC0DE, 16'h0, 1'b1);
    runFrame(1'b0, 5'h0A, 5'h15, 16'h0, 16'h9E37, 1'b1);
    // R10: a write leaves the last read word in place
    held = rdData;
    runFrame(1'b1, 5'h1F, 5'h00, 16'hFFFF, 16'h0, 1'b0);
    check(rdData == held, "R10 read data held over write", rdData, held);
    runFrame(1'b0, 5'h00, 5'h1F, 16'h0, 16'h8001, 1'b0);
    check(rdData == 16'h8001, "R10 updated by next read", rdData, 16'h8001);
    summary();
    $finish;
  end

endmodule